// File: doc/BRIEF.md
# Descriptor-Driven Transfer Sequencer

This block runs one DMA channel through a three-level transfer (bytes per array, arrays per frame, frames per block). The transfer is described by an eight-word descriptor kept in a small slot memory. Software fills the slots through a word-wide register port. Slot `ACT_SLOT` is the channel's active descriptor. A hardware event, a software start or a chain request from another channel's completion each counts as a trigger. A trigger makes the block emit one address/length request per cycle on its request port. Moving the data is left to a downstream engine.

After each trigger the block writes the advanced addresses and counts back to the active slot. It then pulses its interrupt and chain outputs as the descriptor's option word asks. When the last array of the last frame has gone out, the block overwrites the active slot with the slot named by the link field. A link of all ones blanks the slot instead, so later triggers find nothing to do.

Top module: `xfer_seq`

## Requirements
- R1: After reset no request or pulse is driven and every slot word reads as zero.
- R2: A register write to address {slot, word} (word index in the low 3 bits) stores the 32-bit value. The read port returns that word combinationally.
- R3: While idle, a trigger on `evt_trig`, `sw_trig` or `chain_in` starts work on the active slot. Requests begin the cycle after the trigger. A trigger that arrives while a trigger is still being worked on, including its write-back cycle, is dropped.
- R4: The descriptor words, by index, are: 0 options; 1 source address; 2 A count in bits 15:0 and B count in bits 31:16; 3 destination address; 4 source B stride in bits 15:0 and destination B stride in bits 31:16; 5 link slot in bits 15:0 and B reload in bits 31:16; 6 source C stride in bits 15:0 and destination C stride in bits 31:16; 7 C count in bits 15:0.
- R5: With option bit 2 clear (A-synchronized), each trigger emits exactly one request whose length is the A count.
- R6: With option bit 2 set (AB-synchronized), each trigger emits requests on consecutive cycles until the current frame's B count is used up.
- R7: Within a frame each address advances by its signed B stride. After the last array of a frame it advances by its signed C stride instead, the B count reloads and the C count drops by one.
- R8: Option bit 0 set holds the source address constant, and bit 1 does the same for the destination.
- R9: A trigger that ends the block is final. It pulses `irq_out` if option bit 20 is set and `chain_out` if bit 22 is set. Any other trigger uses bits 21 and 23 instead. `done_code` carries option bits 17:12 while a pulse is driven.
- R10: With option bit 11 clear, the pulse comes one cycle after the last request of the trigger. With it set, the pulse comes in the same cycle as the last request.
- R11: After a non-final trigger, words 1, 2, 3 and 7 of the active slot hold the advanced addresses and counts. Word 7 has its upper half zero.
- R12: After a final trigger, the active slot receives a copy of the slot named by the low link bits. A link of 16'hFFFF zeroes the slot instead. A trigger is ignored when the A, B or C count of the active slot is zero.
- R13: With option bit 3 set, the active slot is never changed by the block: no write-back and no link copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_trig | input | 1 | Hardware event trigger |
| sw_trig | input | 1 | Software start trigger |
| chain_in | input | 1 | Chain trigger from another channel |
| reg_we | input | 1 | Slot memory write strobe |
| reg_addr | input | AW | Slot memory word address {slot, word} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data at reg_addr |
| req_valid | output | 1 | A request is presented this cycle |
| req_src | output | 32 | Request source address |
| req_dst | output | 32 | Request destination address |
| req_len | output | 16 | Request length in bytes |
| irq_out | output | 1 | Completion interrupt pulse |
| chain_out | output | 1 | Chain request pulse |
| done_code | output | 6 | Completion code sent with the pulses |

## Verification
The bench targets the frame boundary, where a design that added the B stride instead of the C stride would run on into the wrong region. A negative C stride on the destination would expose missing sign extension. The final trigger is exercised with both a real link and the all-ones link. A design that reloaded wrongly would emit requests from a stale or blanked descriptor, or would fail to ignore the trigger that follows. A trigger injected into a busy AB burst, and static descriptors that must repeat the same array, catch designs that restart mid-transfer or overwrite a slot they must leave alone.

// File: rtl/xfer_seq.sv
module xfer_seq #(
  parameter int NSLOT = 8,
  parameter int ACT_SLOT = 0,
  localparam int SW = $clog2(NSLOT),
  localparam int AW = SW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_trig,
  input  logic          sw_trig,
  input  logic          chain_in,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          req_valid,
  output logic [31:0]   req_src,
  output logic [31:0]   req_dst,
  output logic [15:0]   req_len,
  output logic          irq_out,
  output logic          chain_out,
  output logic [5:0]    done_code
);

  localparam int NWORD = NSLOT * 8;
  localparam logic [AW-1:0] BASE_A = AW'(ACT_SLOT * 8);
  localparam logic [AW-1:0] I_OPT = BASE_A + AW'(0);
  localparam logic [AW-1:0] I_SRC = BASE_A + AW'(1);
  localparam logic [AW-1:0] I_AB  = BASE_A + AW'(2);
  localparam logic [AW-1:0] I_DST = BASE_A + AW'(3);
  localparam logic [AW-1:0] I_BS  = BASE_A + AW'(4);
  localparam logic [AW-1:0] I_LK  = BASE_A + AW'(5);
  localparam logic [AW-1:0] I_CS  = BASE_A + AW'(6);
  localparam logic [AW-1:0] I_CC  = BASE_A + AW'(7);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WB} st_t;

  logic [31:0] mem [NWORD];
  st_t st;

  logic        f_csrc, f_cdst, f_ab, f_stat, f_early, f_fie, f_iie, f_fce, f_ice;
  logic [5:0]  code_r;
  logic [31:0] src_r, dst_r;
  logic [15:0] acnt_r, bcnt_r, ccnt_r, rld_r, lnk_r, sb_r, db_r, sc_r, dc_r;
  logic        fin_r;

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  wire        trig     = evt_trig | sw_trig | chain_in;
  wire [31:0] d_opt    = mem[I_OPT];
  wire [31:0] d_ab     = mem[I_AB];
  wire [15:0] d_ccnt   = mem[I_CC][15:0];
  wire        null_d   = (d_ab[15:0] == 16'd0) || (d_ab[31:16] == 16'd0) || (d_ccnt == 16'd0);
  wire        last_arr = (bcnt_r == 16'd1);
  wire        last_all = last_arr && (ccnt_r == 16'd1);
  wire        trig_end = last_arr || !f_ab;
  wire [15:0] s_step   = last_arr ? sc_r : sb_r;
  wire [15:0] d_step   = last_arr ? dc_r : db_r;
  wire        fire     = (st == S_RUN && trig_end && f_early) || (st == S_WB && !f_early);
  wire        fin_now  = (st == S_RUN) ? last_all : fin_r;
  wire [AW-1:0] lk_base = {lnk_r[SW-1:0], 3'b000};

  assign reg_rdata = mem[reg_addr];
  assign req_valid = (st == S_RUN);
  assign req_src   = src_r;
  assign req_dst   = dst_r;
  assign req_len   = acnt_r;
  assign irq_out   = fire && (fin_now ? f_fie : f_iie);
  assign chain_out = fire && (fin_now ? f_fce : f_ice);
  assign done_code = code_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {f_csrc, f_cdst, f_ab, f_stat, f_early, f_fie, f_iie, f_fce, f_ice} <= '0;
      code_r <= '0;
      src_r <= '0; dst_r <= '0;
      acnt_r <= '0; bcnt_r <= '0; ccnt_r <= '0; rld_r <= '0; lnk_r <= '0;
      sb_r <= '0; db_r <= '0; sc_r <= '0; dc_r <= '0;
      fin_r <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (trig && !null_d) begin
          f_csrc  <= d_opt[0];
          f_cdst  <= d_opt[1];
          f_ab    <= d_opt[2];
          f_stat  <= d_opt[3];
          f_early <= d_opt[11];
          code_r  <= d_opt[17:12];
          f_fie   <= d_opt[20];
          f_iie   <= d_opt[21];
          f_fce   <= d_opt[22];
          f_ice   <= d_opt[23];
          src_r   <= mem[I_SRC];
          dst_r   <= mem[I_DST];
          acnt_r  <= d_ab[15:0];
          bcnt_r  <= d_ab[31:16];
          sb_r    <= mem[I_BS][15:0];
          db_r    <= mem[I_BS][31:16];
          lnk_r   <= mem[I_LK][15:0];
          rld_r   <= mem[I_LK][31:16];
          sc_r    <= mem[I_CS][15:0];
          dc_r    <= mem[I_CS][31:16];
          ccnt_r  <= d_ccnt;
          st      <= S_RUN;
        end
        S_RUN: begin
          if (!f_csrc) src_r <= src_r + sx(s_step);
          if (!f_cdst) dst_r <= dst_r + sx(d_step);
          if (last_arr) begin
            bcnt_r <= rld_r;
            ccnt_r <= ccnt_r - 16'd1;
          end else begin
            bcnt_r <= bcnt_r - 16'd1;
          end
          if (trig_end) begin
            fin_r <= last_all;
            st    <= S_WB;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORD; i++) mem[i] <= '0;
    end else begin
      if (reg_we) mem[reg_addr] <= reg_wdata;
      if (st == S_WB && !f_stat) begin
        if (!fin_r) begin
          mem[I_SRC] <= src_r;
          mem[I_DST] <= dst_r;
          mem[I_AB]  <= {bcnt_r, acnt_r};
          mem[I_CC]  <= {16'h0000, ccnt_r};
        end else if (lnk_r == 16'hFFFF) begin
          for (int k = 0; k < 8; k++) mem[BASE_A + AW'(k)] <= '0;
        end else begin
          for (int k = 0; k < 8; k++) mem[BASE_A + AW'(k)] <= mem[lk_base + AW'(k)];
        end
      end
    end
  end

  a_r5_one_array: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !f_ab) |=> !req_valid);

  a_r6_ab_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && f_ab && bcnt_r != 16'd1) |=> req_valid);

  a_r8_const_src: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && f_csrc) |=> (!req_valid || $stable(req_src)));

  a_r12_null_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && trig && null_d) |=> !req_valid);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out || chain_out) |=> !(irq_out || chain_out));

  a_r5_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != 16'd0));

endmodule

// File: tb/xfer_seq_tb_top.sv
module xfer_seq_tb_top;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_trig = 1'b0, sw_trig = 1'b0, chain_in = 1'b0, reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, req_src, req_dst;
  logic [15:0] req_len;
  logic req_valid, irq_out, chain_out;
  logic [5:0] done_code;

  always #5 clk = ~clk;

  xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .evt_trig(evt_trig), .sw_trig(sw_trig), .chain_in(chain_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
    .irq_out(irq_out), .chain_out(chain_out), .done_code(done_code)
  );

  typedef struct packed {
    bit v; bit irq; bit ch; bit [5:0] code;
    bit [31:0] src; bit [31:0] dst; bit [15:0] len;
  } ent_t;

  ent_t q[$];
  bit [31:0] m [64];
  int errors = 0, checks = 0;
  bit running = 1'b0, done = 1'b0;
  string cur_req = "R1";

  function automatic bit [31:0] sx(input bit [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  always @(negedge clk) if (running) begin
    ent_t e;
    bit bad;
    e = (q.size() > 0) ? q.pop_front() : '0;
    checks++;
    bad = (req_valid !== e.v) || (irq_out !== e.irq) || (chain_out !== e.ch);
    if (e.v && (req_src !== e.src || req_dst !== e.dst || req_len !== e.len)) bad = 1'b1;
    if ((e.irq || e.ch) && done_code !== e.code) bad = 1'b1;
    if (bad) begin
      errors++;
      $display("FAIL %s: act v=%0b irq=%0b ch=%0b code=%0d src=%h dst=%h len=%0d exp v=%0b irq=%0b ch=%0b code=%0d src=%h dst=%h len=%0d",
        cur_req, req_valid, irq_out, chain_out, done_code, req_src, req_dst, req_len,
        e.v, e.irq, e.ch, e.code, e.src, e.dst, e.len);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
    reg_we = 1'b0; evt_trig = 1'b0; sw_trig = 1'b0; chain_in = 1'b0;
  endtask

  task automatic wrw(input int s, input int w, input bit [31:0] v);
    tick();
    reg_we = 1'b1; reg_addr = AW'(s * 8 + w); reg_wdata = v;
    m[s * 8 + w] = v;
  endtask

  task automatic model_trig();
    bit [31:0] o, s, d;
    bit [15:0] a, b, c, rld, lnk, sb, db, sc, dc;
    bit last, fin, ab, endt;
    ent_t e;
    if (q.size() != 0) return;
    o = m[0]; s = m[1]; a = m[2][15:0]; b = m[2][31:16]; d = m[3];
    sb = m[4][15:0]; db = m[4][31:16]; lnk = m[5][15:0]; rld = m[5][31:16];
    sc = m[6][15:0]; dc = m[6][31:16]; c = m[7][15:0];
    if (a == 0 || b == 0 || c == 0) return;
    ab = o[2];
    fin = 1'b0;
    forever begin
      last = (b == 1);
      fin = last && (c == 1);
      endt = last || !ab;
      e = '0;
      e.v = 1'b1; e.src = s; e.dst = d; e.len = a; e.code = o[17:12];
      if (endt && o[11]) begin
        e.irq = fin ? o[20] : o[21];
        e.ch  = fin ? o[22] : o[23];
      end
      q.push_back(e);
      if (!o[0]) s = s + sx(last ? sc : sb);
      if (!o[1]) d = d + sx(last ? dc : db);
      if (last) begin b = rld; c = c - 1; end else b = b - 1;
      if (endt) break;
    end
    e = '0;
    e.code = o[17:12];
    if (!o[11]) begin
      e.irq = fin ? o[20] : o[21];
      e.ch  = fin ? o[22] : o[23];
    end
    q.push_back(e);
    q.push_back('0);
    if (!o[3]) begin
      if (!fin) begin
        m[1] = s; m[3] = d; m[2] = {b, a}; m[7] = {16'h0, c};
      end else if (lnk == 16'hFFFF) begin
        for (int k = 0; k < 8; k++) m[k] = '0;
      end else begin
        for (int k = 0; k < 8; k++) m[k] = m[lnk[2:0] * 8 + k];
      end
    end
  endtask

  task automatic fire(input int kind);
    tick();
    if (kind == 0) evt_trig = 1'b1;
    else if (kind == 1) sw_trig = 1'b1;
    else chain_in = 1'b1;
    model_trig();
  endtask

  task automatic settle();
    repeat (12) tick();
  endtask

  task automatic chk_slot(input int s, input string tag);
    for (int w = 0; w < 8; w++) begin
      tick();
      reg_addr = AW'(s * 8 + w);
      #1;
      checks++;
      if (reg_rdata !== m[s * 8 + w]) begin
        errors++;
        $display("FAIL %s: slot %0d word %0d act=%h exp=%h", tag, s, w, reg_rdata, m[s * 8 + w]);
      end
    end
  endtask

  initial begin
    repeat (3) tick();
    checks++;
    if (req_valid !== 1'b0 || irq_out !== 1'b0 || chain_out !== 1'b0) begin
      errors++;
      $display("FAIL R1: outputs in reset act=%b%b%b exp=000", req_valid, irq_out, chain_out);
    end
    rst_n = 1'b1;
    running = 1'b1;
    cur_req = "R1";
    chk_slot(0, "R1");

    cur_req = "R2";
    wrw(7, 5, 32'hCAFE_0123);
    wrw(7, 6, 32'h0BAD_F00D);
    chk_slot(7, "R2");

    // R4 layout, A-synchronized incrementing descriptor with a link to slot 2
    wrw(0, 0, 32'h0070_5000);
    wrw(0, 1, 32'h0000_1000);
    wrw(0, 2, 32'h0003_0004);
    wrw(0, 3, 32'h0000_2000);
    wrw(0, 4, 32'h0020_0010);
    wrw(0, 5, 32'h0003_0002);
    wrw(0, 6, 32'hFFF8_0064);
    wrw(0, 7, 32'h0000_0002);
    // AB-synchronized, constant source, early completion, null link
    wrw(2, 0, 32'h0090_9805);
    wrw(2, 1, 32'h0000_4000);
    wrw(2, 2, 32'h0003_0008);
    wrw(2, 3, 32'h0000_5000);
    wrw(2, 4, 32'h0008_0000);
    wrw(2, 5, 32'h0003_FFFF);
    wrw(2, 6, 32'h0100_0000);
    wrw(2, 7, 32'h0000_0002);
    settle();

    cur_req = "R3/R4/R5/R7/R9/R10";
    fire(0); settle();
    fire(1); settle();
    fire(2); settle();
    cur_req = "R11";
    chk_slot(0, "R11");
    cur_req = "R5/R7/R9";
    fire(0); settle();
    fire(1); settle();
    fire(2); settle();
    cur_req = "R12";
    chk_slot(0, "R12");

    cur_req = "R3/R6/R8/R10";
    fire(0);
    fire(1);
    settle();
    cur_req = "R6/R9/R12";
    fire(2); settle();
    chk_slot(0, "R12");
    cur_req = "R12";
    fire(0); settle();

    // R13 static descriptor, constant destination
    wrw(0, 0, 32'h0060_300A);
    wrw(0, 1, 32'h0000_8000);
    wrw(0, 2, 32'h0002_0010);
    wrw(0, 3, 32'h0000_9000);
    wrw(0, 4, 32'h0000_0040);
    wrw(0, 5, 32'h0002_0005);
    wrw(0, 6, 32'h0000_0000);
    wrw(0, 7, 32'h0000_0001);
    settle();
    cur_req = "R13/R8";
    fire(1); settle();
    fire(0); settle();
    fire(2); settle();
    chk_slot(0, "R13");
    wrw(0, 2, 32'h0001_0010);
    wrw(0, 5, 32'h0001_0002);
    settle();
    cur_req = "R13/R9";
    fire(1); settle();
    chk_slot(0, "R13");

    running = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule